// File: doc/BRIEF.md
# Reservation Station Pool with Operand Wakeup

This block keeps a small set of waiting operations for an out-of-order floating-point datapath. An in-order issue stage presents at most one operation per cycle. Each operand arrives either as a value or as the tag of the station that will produce it. The pool puts the operation in the lowest-numbered free entry and reports that entry's number as the operation's tag. The issue stage uses the tag to rename its destination register. When every entry is occupied, the pool raises a stall and accepts nothing.

Pending operands are filled by watching one shared result bus, which carries a tag and a value. Every waiting slot whose tag matches takes the value in the same cycle. This includes a slot being written by an issue in that same cycle. An entry with both operands present becomes ready. Each cycle, the lowest-numbered ready entry is sent through a registered dispatch port to the functional unit. The entry then holds its place until its own tag appears on the result bus. At that point it is released and can be reused on the following cycle.

Top module: `rsp_pool`

## Requirements
- R1: After a synchronous reset, every entry is free: `iss_stall` is 0, `iss_tag` is 0 and `disp_valid` is 0.
- R2: `iss_tag` always shows the lowest-numbered free entry. An accepted issue is placed in that entry, and the entry's number appears as `disp_tag` when the operation dispatches.
- R3: `iss_stall` is 1 exactly when all entries are busy. An issue presented while `iss_stall` is 1 is dropped and never dispatches.
- R4: An operand marked valid at issue is copied into the entry. It leaves on `disp_a` (first operand) or `disp_b` (second operand) unchanged.
- R5: An operand marked not valid at issue waits for its tag on the result bus. The value carried with that tag is the value dispatched.
- R6: One result broadcast fills every waiting slot whose tag matches, in every entry.
- R7: A broadcast in the same cycle as an issue that names its tag is captured by the newly allocated entry.
- R8: An entry does not dispatch while either of its operands is missing.
- R9: When several entries are ready, the lowest-numbered one dispatches first. At most one dispatch occurs per cycle.
- R10: A dispatched entry stays busy until its own tag is broadcast. It is then free, and can be allocated, on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue stage presents an operation |
| iss_op | input | OP_W | Operation code |
| iss_a_valid | input | 1 | First operand holds a value |
| iss_a_tag | input | TAG_W | Producer tag of first operand when not valid |
| iss_a_val | input | DATA_W | First operand value when valid |
| iss_b_valid | input | 1 | Second operand holds a value |
| iss_b_tag | input | TAG_W | Producer tag of second operand when not valid |
| iss_b_val | input | DATA_W | Second operand value when valid |
| iss_stall | output | 1 | All entries busy; issue is not accepted |
| iss_tag | output | TAG_W | Entry (tag) the next accepted issue will occupy |
| bc_valid | input | 1 | Result bus carries a result |
| bc_tag | input | TAG_W | Tag of the producing entry |
| bc_val | input | DATA_W | Result value |
| disp_valid | output | 1 | Registered dispatch to the functional unit |
| disp_tag | output | TAG_W | Tag of the dispatched entry |
| disp_op | output | OP_W | Dispatched operation code |
| disp_a | output | DATA_W | Dispatched first operand |
| disp_b | output | DATA_W | Dispatched second operand |

## Verification
The bench builds the pool with four entries, 16-bit data and 3-bit opcodes. With four entries, the full condition and an issue attempted while stalled are reached after only four allocations. The same setting makes it possible to wake every entry with one broadcast and to watch the ready entries leave one per cycle in index order. The bench also acts as the functional unit itself, choosing when each result tag is broadcast. This lets it place a broadcast in the same cycle as an issue and show an entry being released and then reused.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  // Operand slot positions inside an entry.
  typedef enum logic [0:0] {SLOT_A = 1'b0, SLOT_B = 1'b1} slot_e;
  localparam int NUM_SLOTS = 2;
endpackage

// File: rtl/rsp_prio_enc.sv
module rsp_prio_enc #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Lowest set bit wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rsp_entry.sv
module rsp_entry
  import rsp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 2,
  parameter int MY_TAG = 0
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               alloc,
  input  logic [OP_W-1:0]                    in_op,
  input  logic [NUM_SLOTS-1:0]               in_vld,
  input  logic [NUM_SLOTS-1:0][TAG_W-1:0]    in_tag,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0]   in_val,
  input  logic                               bc_valid,
  input  logic [TAG_W-1:0]                   bc_tag,
  input  logic [DATA_W-1:0]                  bc_val,
  input  logic                               take,
  output logic                               busy,
  output logic                               ready,
  output logic [OP_W-1:0]                    op,
  output logic [DATA_W-1:0]                  a_val,
  output logic [DATA_W-1:0]                  b_val
);
  logic [NUM_SLOTS-1:0]             slot_vld;
  logic [NUM_SLOTS-1:0][TAG_W-1:0]  slot_tag;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_val;
  logic                             sent;
  logic                             own_result;

  assign own_result = bc_valid && (bc_tag == TAG_W'(MY_TAG));

  // Operand slots: value at issue, or wakeup from the result bus.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic hit_new;
    logic hit_wait;
    assign hit_new  = bc_valid && (bc_tag == in_tag[s]);
    assign hit_wait = bc_valid && (bc_tag == slot_tag[s]);

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_vld[s] <= 1'b0;
      end else if (alloc) begin
        slot_vld[s] <= in_vld[s] || hit_new;
        slot_tag[s] <= in_tag[s];
        slot_val[s] <= in_vld[s] ? in_val[s] : bc_val;
      end else if (busy && !slot_vld[s] && hit_wait) begin
        slot_vld[s] <= 1'b1;
        slot_val[s] <= bc_val;
      end
    end

    // R4/R5: a captured operand does not change while the entry stays busy.
    a_r4_value_held: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy) && $past(slot_vld[s])) |-> (slot_val[s] == $past(slot_val[s])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sent <= 1'b0;
    end else if (alloc) begin
      busy <= 1'b1;
      sent <= 1'b0;
      op   <= in_op;
    end else begin
      if (take) sent <= 1'b1;
      if (busy && sent && own_result) begin
        busy <= 1'b0;
        sent <= 1'b0;
      end
    end
  end

  assign ready = busy && !sent && (&slot_vld);
  assign a_val = slot_val[SLOT_A];
  assign b_val = slot_val[SLOT_B];

  a_r3_alloc_only_free: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !busy);
  a_r8_take_has_operands: assert property (@(posedge clk) disable iff (rst)
    take |-> (busy && (&slot_vld)));
  a_r10_free_on_own_tag: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(own_result && sent));
endmodule

// File: rtl/rsp_pool.sv
module rsp_pool
  import rsp_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int DATA_W  = 32,
  parameter int OP_W    = 4,
  parameter int TAG_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic              iss_a_valid,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic              iss_b_valid,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic [DATA_W-1:0] iss_b_val,
  output logic              iss_stall,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic              disp_valid,
  output logic [TAG_W-1:0]  disp_tag,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b
);
  logic [NUM_ENT-1:0] busy_vec;
  logic [NUM_ENT-1:0] ready_vec;
  logic [NUM_ENT-1:0] alloc_vec;
  logic [NUM_ENT-1:0] take_vec;
  logic [OP_W-1:0]    op_arr [NUM_ENT];
  logic [DATA_W-1:0]  a_arr  [NUM_ENT];
  logic [DATA_W-1:0]  b_arr  [NUM_ENT];

  logic               free_found;
  logic [TAG_W-1:0]   free_idx;
  logic               rdy_found;
  logic [TAG_W-1:0]   rdy_idx;

  logic [NUM_SLOTS-1:0]             in_vld;
  logic [NUM_SLOTS-1:0][TAG_W-1:0]  in_tag;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] in_val;

  assign in_vld = {iss_b_valid, iss_a_valid};
  assign in_tag = {iss_b_tag, iss_a_tag};
  assign in_val = {iss_b_val, iss_a_val};

  rsp_prio_enc #(.N(NUM_ENT), .IW(TAG_W)) i_free_pick (
    .req(~busy_vec), .found(free_found), .idx(free_idx));

  rsp_prio_enc #(.N(NUM_ENT), .IW(TAG_W)) i_ready_pick (
    .req(ready_vec), .found(rdy_found), .idx(rdy_idx));

  assign iss_stall = !free_found;
  assign iss_tag   = free_idx;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    assign alloc_vec[e] = iss_valid && free_found && (free_idx == TAG_W'(e));
    assign take_vec[e]  = rdy_found && (rdy_idx == TAG_W'(e));

    rsp_entry #(
      .DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W), .MY_TAG(e)
    ) i_entry (
      .clk(clk), .rst(rst),
      .alloc(alloc_vec[e]),
      .in_op(iss_op), .in_vld(in_vld), .in_tag(in_tag), .in_val(in_val),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .take(take_vec[e]),
      .busy(busy_vec[e]), .ready(ready_vec[e]),
      .op(op_arr[e]), .a_val(a_arr[e]), .b_val(b_arr[e])
    );
  end

  // Registered dispatch port.
  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
    end else begin
      disp_valid <= rdy_found;
    end
    disp_tag <= rdy_idx;
    disp_op  <= op_arr[rdy_idx];
    disp_a   <= a_arr[rdy_idx];
    disp_b   <= b_arr[rdy_idx];
  end

  a_r9_single_take: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take_vec));
  a_r3_stall_means_full: assert property (@(posedge clk) disable iff (rst)
    iss_stall |-> (&busy_vec));
  a_r3_no_alloc_when_full: assert property (@(posedge clk) disable iff (rst)
    iss_stall |-> (alloc_vec == '0));
  a_r2_alloc_single: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alloc_vec));
endmodule

// File: tb/test_rsp_pool.sv
module test_rsp_pool;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int OW = 3;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 0, iss_a_valid = 0, iss_b_valid = 0, bc_valid = 0;
  logic [OW-1:0] iss_op = '0;
  logic [TW-1:0] iss_a_tag = '0, iss_b_tag = '0, bc_tag = '0;
  logic [DW-1:0] iss_a_val = '0, iss_b_val = '0, bc_val = '0;
  logic iss_stall, disp_valid;
  logic [TW-1:0] iss_tag, disp_tag;
  logic [OW-1:0] disp_op;
  logic [DW-1:0] disp_a, disp_b;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;

  int          lg_n = 0;
  logic [TW-1:0] lg_tag [32];
  logic [OW-1:0] lg_op  [32];
  logic [DW-1:0] lg_a   [32];
  logic [DW-1:0] lg_b   [32];
  int          lg_cyc [32];

  rsp_pool #(.NUM_ENT(N), .DATA_W(DW), .OP_W(OW), .TAG_W(TW)) i_rsp_pool (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_a_valid(iss_a_valid), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
    .iss_b_valid(iss_b_valid), .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
    .iss_stall(iss_stall), .iss_tag(iss_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
    .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
    .disp_a(disp_a), .disp_b(disp_b)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst && disp_valid && lg_n < 32) begin
      lg_tag[lg_n] = disp_tag;
      lg_op[lg_n]  = disp_op;
      lg_a[lg_n]   = disp_a;
      lg_b[lg_n]   = disp_b;
      lg_cyc[lg_n] = cyc;
      lg_n++;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_issue(int op, bit av, int at, int aval, bit bv, int bt, int bval);
    iss_valid   = 1'b1;
    iss_op      = OW'(op);
    iss_a_valid = av;  iss_a_tag = TW'(at); iss_a_val = DW'(aval);
    iss_b_valid = bv;  iss_b_tag = TW'(bt); iss_b_val = DW'(bval);
  endtask

  task automatic issue_one(int op, bit av, int at, int aval, bit bv, int bt, int bval);
    drive_issue(op, av, at, aval, bv, bt, bval);
    step(1);
    iss_valid = 1'b0;
  endtask

  task automatic bcast_one(int tag, int val);
    bc_valid = 1'b1; bc_tag = TW'(tag); bc_val = DW'(val);
    step(1);
    bc_valid = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1; iss_valid = 1'b0; bc_valid = 1'b0;
    step(3);
    rst = 1'b0;
    lg_n = 0;
    step(1);
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1", "iss_stall", int'(iss_stall), 0);
    chk("R1", "iss_tag", int'(iss_tag), 0);
    chk("R1", "disp_valid", int'(disp_valid), 0);
  endtask

  task automatic t_values_at_issue;
    do_reset();
    chk("R2", "tag before issue", int'(iss_tag), 0);
    issue_one(3, 1, 0, 'h11, 1, 0, 'h22);
    chk("R2", "next free tag", int'(iss_tag), 1);
    step(3);
    chk("R4", "dispatch count", lg_n, 1);
    chk("R2", "disp_tag", int'(lg_tag[0]), 0);
    chk("R4", "disp_op", int'(lg_op[0]), 3);
    chk("R4", "disp_a", int'(lg_a[0]), 'h11);
    chk("R4", "disp_b", int'(lg_b[0]), 'h22);
  endtask

  task automatic t_wakeup;
    do_reset();
    issue_one(1, 1, 0, 'h5, 0, 3, 0);
    step(3);
    chk("R8", "no dispatch while waiting", lg_n, 0);
    bcast_one(3, 'h77);
    step(3);
    chk("R5", "dispatch count", lg_n, 1);
    chk("R5", "disp_b from bus", int'(lg_b[0]), 'h77);
    chk("R4", "disp_a kept", int'(lg_a[0]), 'h5);
  endtask

  task automatic t_multi_capture;
    do_reset();
    issue_one(2, 0, 2, 0, 1, 0, 'h31);
    issue_one(4, 1, 0, 'h41, 0, 2, 0);
    step(2);
    chk("R8", "both waiting", lg_n, 0);
    bcast_one(2, 'h99);
    step(4);
    chk("R6", "two dispatches", lg_n, 2);
    chk("R9", "first tag", int'(lg_tag[0]), 0);
    chk("R9", "second tag", int'(lg_tag[1]), 1);
    chk("R9", "back to back", lg_cyc[1] - lg_cyc[0], 1);
    chk("R6", "entry0 a", int'(lg_a[0]), 'h99);
    chk("R6", "entry1 b", int'(lg_b[1]), 'h99);
  endtask

  task automatic t_same_cycle;
    do_reset();
    drive_issue(6, 0, 1, 0, 1, 0, 'h66);
    bc_valid = 1'b1; bc_tag = TW'(1); bc_val = DW'('h55);
    step(1);
    iss_valid = 1'b0; bc_valid = 1'b0;
    step(3);
    chk("R7", "dispatch count", lg_n, 1);
    chk("R7", "disp_a same-cycle capture", int'(lg_a[0]), 'h55);
    chk("R7", "disp_b", int'(lg_b[0]), 'h66);
  endtask

  task automatic t_full_and_free;
    do_reset();
    for (int k = 0; k < N; k++) begin
      chk("R2", "lowest free tag", int'(iss_tag), k);
      chk("R3", "no stall before full", int'(iss_stall), 0);
      issue_one(k, 0, 3, 0, 1, 0, 'h10 + k);
    end
    chk("R3", "stall when full", int'(iss_stall), 1);
    issue_one(7, 1, 0, 'hEE, 1, 0, 'hEE);
    bcast_one(3, 'hAA);
    step(7);
    chk("R3", "dispatch count (stalled issue dropped)", lg_n, N);
    for (int k = 0; k < N; k++) begin
      chk("R9", "dispatch order tag", int'(lg_tag[k]), k);
      chk("R3", "dispatch op", int'(lg_op[k]), k);
      chk("R6", "woken operand", int'(lg_a[k]), 'hAA);
    end
    chk("R10", "still full without results", int'(iss_stall), 1);
    bcast_one(2, 'h0);
    chk("R10", "stall clears after own tag", int'(iss_stall), 0);
    chk("R10", "freed tag offered", int'(iss_tag), 2);
    issue_one(5, 1, 0, 'h123, 1, 0, 'h456);
    chk("R10", "full again after reuse", int'(iss_stall), 1);
    step(3);
    chk("R10", "reused dispatch count", lg_n, N + 1);
    chk("R10", "reused tag", int'(lg_tag[N]), 2);
    chk("R4", "reused a", int'(lg_a[N]), 'h123);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_values_at_issue();
    t_wakeup();
    t_multi_capture();
    t_same_cycle();
    t_full_and_free();
    finish_run();
  end
endmodule